// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

A single-clock synchronous static RAM model for use as a cache or buffer store. Every input is captured on the rising clock edge. A read that is captured on one edge puts its word into an output register on the next edge. A write goes into the array on the edge that captures it. Write enables work in two ways. A global strobe writes the whole word. A byte-write qualifier lets per-lane strobes select which byte lanes are written.

A load cycle starts an access at an external address. Later advance cycles step a 2-bit counter that forms the two lowest address bits of each access, so a burst stays inside an aligned group of four words. The counter follows a linear sequence or an interleaved sequence. The sequence is chosen on the cycle that loads the address.

The word is selected only when all three chip enables are at their active levels. After a read, a deselect keeps the read-data driver on for two more cycles. An asynchronous output-enable gates the drive flag. A sleep input freezes the whole block, and the memory contents are kept. The array depth, word width and lane count are parameters.

Top module: `burst_sram`

## Requirements
- R1: While rst_n is low at a clock edge, the registered state is cleared. After that edge, rdata is 0 and rdata_oe is 0.
- R2: A read captured at edge k puts the addressed word on rdata at edge k+1, and rdata_oe goes to 1 from that edge while oe_n is low.
- R3: With seq_lin=1 captured at load, advance cycles access low address bits (start+n) mod 4 for n=1,2,3,...
- R4: With seq_lin=0 captured at load, advance cycles access low address bits start XOR (n mod 4).
- R5: A cycle with gw_n low is a write of every byte lane, whatever bwe_n and be_n hold.
- R6: With gw_n high and bwe_n low, only the lanes whose be_n bit is 0 are written (bit i is byte i, bits 8i+7..8i). With gw_n and bwe_n both high, the cycle is a read.
- R7: A load cycle selects the word only when ce0_n=0, ce1=1 and ce2_n=0. Any other combination is a deselect: nothing is written, and later advance cycles do nothing until the next selected load.
- R8: A deselect captured at edge k leaves rdata_oe unchanged at edge k+1. It clears rdata_oe at edge k+2 unless a read was captured at edge k+1. A write captured at edge k clears rdata_oe at edge k+1.
- R9: rdata_oe follows oe_n combinationally: it is 0 whenever oe_n is 1, with no clock edge needed.
- R10: While sleep is 1, load, advance and write cycles have no effect. The array, the burst state and rdata/rdata_oe keep their values.
- R11: A read of an address in the cycle after a write to it returns the newly written data.
- R12: The counter steps only on cycles with ld_n=1 and adv_n=0. With both high it holds. It wraps inside the four-word group, and the upper address bits stay unchanged.
- R13: A change of seq_lin after the load does not change the sequence of the burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | AW | Word address, captured on load cycles |
| ld_n | input | 1 | Address-load strobe, active low |
| adv_n | input | 1 | Burst-advance strobe, active low |
| ce0_n | input | 1 | Chip enable, active low |
| ce1 | input | 1 | Chip enable, active high |
| ce2_n | input | 1 | Chip enable, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write qualifier, active low |
| be_n | input | NB | Per-lane byte strobes, active low |
| seq_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Freeze operations and hold state, active high |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data from the output register |
| rdata_oe | output | 1 | Read-data drive-enable flag |

## Verification
The hardest case to reach is the second cycle of the double deselect. The driver must stay on through one cycle with no new read, and the outcome depends on what the following cycle does: a read keeps it on, anything else turns it off. Directed sequences place a read, then a deselect, then idle, read or write cycles at exact offsets. The random phase also issues deselect loads often while chip enables, sleep, the burst order and the output enable change from cycle to cycle. A cycle-level model in the bench follows the drive flag and the output register through every one of these mixes.

// File: rtl/burst_sram_pkg.sv
// Package: shared operation code and burst address arithmetic.
// Assumes a 2-bit burst counter, so the group is four words.
package burst_sram_pkg;

    // Operation decoded for the current cycle
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2,
        OP_DS   = 2'd3
    } op_e;

    // Low address bits for a burst position: linear adds, interleaved XORs
    function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                            input logic [1:0] step,
                                            input logic       lin);
        return lin ? (start + step) : (start ^ step);
    endfunction

endpackage

// File: rtl/burst_sram_ctrl.sv
// Module: input decode and burst address generation.
// Finds each cycle's operation (read, write, deselect, idle), the word
// address it touches and the byte-lane write mask.
// Assumes AW >= 3. The burst state is frozen while sleep is high.
module burst_sram_ctrl
    import burst_sram_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sleep,
    input  logic [AW-1:0] addr,
    input  logic          ld_n,
    input  logic          adv_n,
    input  logic          ce0_n,
    input  logic          ce1,
    input  logic          ce2_n,
    input  logic          gw_n,
    input  logic          bwe_n,
    input  logic [NB-1:0] be_n,
    input  logic          seq_lin,
    output op_e           op,
    output logic [AW-1:0] acc_addr,
    output logic [NB-1:0] wmask
);

    localparam int UPW = AW - 2;

    logic [AW-1:0] base_q;
    logic [1:0]    cnt_q;
    logic [1:0]    nxt_cnt;
    logic          lin_q;
    logic          act_q;
    logic          sel;
    logic          wr_req;

    // Decode selection, write type, lane mask and operation for this cycle
    always_comb begin
        sel      = !ce0_n && ce1 && !ce2_n;
        wr_req   = !gw_n || !bwe_n;
        wmask    = !gw_n ? {NB{1'b1}} : (!bwe_n ? ~be_n : {NB{1'b0}});
        nxt_cnt  = cnt_q + 2'd1;
        op       = OP_IDLE;
        acc_addr = addr;
        if (rst_n && !sleep) begin
            if (!ld_n) begin
                op = sel ? (wr_req ? OP_WR : OP_RD) : OP_DS;
            end else if (!adv_n && act_q) begin
                op       = wr_req ? OP_WR : OP_RD;
                acc_addr = {base_q[AW-1:2], burst_lo(base_q[1:0], nxt_cnt, lin_q)};
            end
        end
    end

    // Hold burst base, counter, order and session flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= 2'd0;
            lin_q  <= 1'b0;
            act_q  <= 1'b0;
        end else if (!sleep) begin
            if (!ld_n) begin
                act_q <= sel;
                if (sel) begin
                    base_q <= addr;
                    cnt_q  <= 2'd0;
                    lin_q  <= seq_lin;
                end
            end else if (!adv_n && act_q) begin
                cnt_q <= nxt_cnt;
            end
        end
    end

    // R12: no step without an advance strobe
    p_cnt_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_n && adv_n) |=> $stable(cnt_q));

    // R12: an advance keeps the upper address of the loaded base
    p_group_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_n && op == OP_RD) |-> (acc_addr[AW-1:2] == base_q[UPW+1:2]));

    // R7: an unselected load never writes
    p_desel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_n && !sleep && !ce1) |-> (op == OP_DS));

    // R10: sleep freezes the burst state
    p_sleep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> ($stable(cnt_q) && $stable(base_q) && $stable(act_q)));

endmodule

// File: rtl/burst_sram_array.sv
// Module: storage array with lane-masked write and registered read output.
// A write lands on the edge that captures it. A read address is captured
// and the word leaves through the output register one edge later.
// Assumes DW is a multiple of NB. Array contents are not reset.
module burst_sram_array
    import burst_sram_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16,
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sleep,
    input  op_e           op,
    input  logic [AW-1:0] acc_addr,
    input  logic [NB-1:0] wmask,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] dout
);

    localparam int DEPTH = 1 << AW;
    localparam int LW    = DW / NB;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] raddr_q;
    logic          rd_q;
    logic [DW-1:0] dout_q;

    // Write the selected byte lanes
    always_ff @(posedge clk) begin
        if (op == OP_WR) begin
            for (int g = 0; g < NB; g++) begin
                if (wmask[g]) mem[acc_addr][g*LW +: LW] <= wdata[g*LW +: LW];
            end
        end
    end

    // Capture the read address and load the output register one edge later
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raddr_q <= '0;
            rd_q    <= 1'b0;
            dout_q  <= '0;
        end else if (!sleep) begin
            rd_q <= (op == OP_RD);
            if (op == OP_RD) raddr_q <= acc_addr;
            if (rd_q) dout_q <= mem[raddr_q];
        end
    end

    assign dout = dout_q;

    // R10: output register frozen during sleep
    p_dout_sleep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> $stable(dout_q));

    // R2: no new output word without a pending read
    p_dout_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_q) |=> $stable(dout_q));

endmodule

// File: rtl/burst_sram_drive.sv
// Module: read-data driver timing with double-cycle deselect.
// Tracks the two most recent operations. A read turns the driver on when
// its data appears. A write turns it off at once. A deselect turns it off
// one edge later than a write would. Output enable gates it without a clock.
module burst_sram_drive
    import burst_sram_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sleep,
    input  op_e  op,
    input  logic oe_n,
    output logic rdata_oe
);

    op_e  op_q;
    op_e  op2_q;
    logic drv_q;
    logic drv_d;

    // Next driver state from the operations one and two edges back
    always_comb begin
        drv_d = drv_q;
        if (op_q == OP_RD)       drv_d = 1'b1;
        else if (op_q == OP_WR)  drv_d = 1'b0;
        else if (op2_q == OP_DS) drv_d = 1'b0;
    end

    // Shift the operation history and update the driver
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q  <= OP_IDLE;
            op2_q <= OP_IDLE;
            drv_q <= 1'b0;
        end else if (!sleep) begin
            op_q  <= op;
            op2_q <= op_q;
            drv_q <= drv_d;
        end
    end

    assign rdata_oe = drv_q && !oe_n;

    // R2: read data is driven the edge after the read is captured
    p_rd_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_RD && !sleep) |=> drv_q);

    // R8: write turns the driver off at once
    p_wr_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_WR && !sleep) |=> !drv_q);

    // R8: first cycle after a deselect keeps the driver as it was
    p_ds_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_DS && op2_q != OP_DS && !sleep) |=> (drv_q == $past(drv_q)));

    // R8: second cycle after a deselect turns the driver off unless a read follows
    p_ds_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op2_q == OP_DS && op_q != OP_RD && !sleep) |=> !drv_q);

    // R9: output enable is combinational
    always_comb begin
        if (rst_n && oe_n) begin
            a_oe_gate_r9: assert (!rdata_oe);
        end
    end

endmodule

// File: rtl/burst_sram.sv
// Module: top of the pipelined burst synchronous SRAM.
// Connects the decode and burst logic, the storage array and the driver
// timing. Assumes AW >= 3, DW a multiple of NB, and one clock domain.
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16,
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          ld_n,
    input  logic          adv_n,
    input  logic          ce0_n,
    input  logic          ce1,
    input  logic          ce2_n,
    input  logic          gw_n,
    input  logic          bwe_n,
    input  logic [NB-1:0] be_n,
    input  logic          seq_lin,
    input  logic          oe_n,
    input  logic          sleep,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          rdata_oe
);

    op_e           cur_op;
    logic [AW-1:0] acc_addr;
    logic [NB-1:0] wmask;

    burst_sram_ctrl #(.AW(AW), .NB(NB)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep    (sleep),
        .addr     (addr),
        .ld_n     (ld_n),
        .adv_n    (adv_n),
        .ce0_n    (ce0_n),
        .ce1      (ce1),
        .ce2_n    (ce2_n),
        .gw_n     (gw_n),
        .bwe_n    (bwe_n),
        .be_n     (be_n),
        .seq_lin  (seq_lin),
        .op       (cur_op),
        .acc_addr (acc_addr),
        .wmask    (wmask)
    );

    burst_sram_array #(.AW(AW), .DW(DW), .NB(NB)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep    (sleep),
        .op       (cur_op),
        .acc_addr (acc_addr),
        .wmask    (wmask),
        .wdata    (wdata),
        .dout     (rdata)
    );

    burst_sram_drive u_drive (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep    (sleep),
        .op       (cur_op),
        .oe_n     (oe_n),
        .rdata_oe (rdata_oe)
    );

    // R5: global write enables every lane
    p_gw_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_op == OP_WR && !gw_n) |-> (&wmask));

    // R6: byte writes touch only lanes with their strobe low
    p_bw_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_op == OP_WR && gw_n) |-> ((wmask & be_n) == '0));

endmodule

// File: tb/sim_burst_sram.sv
// Bench: directed corner cases plus seeded random cycles, checked against a
// cycle-level model built from the requirements.
module sim_burst_sram;

    localparam int AW = 6;
    localparam int DW = 16;
    localparam int NB = 2;
    localparam int DEPTH = 1 << AW;

    // Model operation codes
    localparam int M_IDLE = 0;
    localparam int M_RD   = 1;
    localparam int M_WR   = 2;
    localparam int M_DS   = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          ld_n = 1'b1, adv_n = 1'b1;
    logic          ce0_n = 1'b0, ce1 = 1'b1, ce2_n = 1'b0;
    logic          gw_n = 1'b1, bwe_n = 1'b1;
    logic [NB-1:0] be_n = '1;
    logic          seq_lin = 1'b1, oe_n = 1'b0, sleep = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rdata_oe;

    int n_tests = 0;
    int n_fail  = 0;
    string cur_tag = "R2";

    // model state
    logic [DW-1:0] mm [DEPTH];
    logic [AW-1:0] m_base, m_raddr;
    logic [1:0]    m_cnt;
    logic          m_lin, m_act, m_drv;
    int            m_opq, m_opq2;
    logic [DW-1:0] m_dout;

    always #10 clk = ~clk;

    burst_sram #(.AW(AW), .DW(DW), .NB(NB)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ld_n(ld_n), .adv_n(adv_n),
        .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n), .gw_n(gw_n), .bwe_n(bwe_n),
        .be_n(be_n), .seq_lin(seq_lin), .oe_n(oe_n), .sleep(sleep),
        .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    function automatic logic [DW-1:0] pat(input int a);
        return DW'(a * 16'h0101) ^ 16'h5A00;
    endfunction

    function automatic logic [1:0] blo(input logic [1:0] s, input logic [1:0] n, input logic lin);
        if (lin) return 2'((int'(s) + int'(n)) % 4);
        return s ^ n;
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Model one rising edge from the inputs currently applied
    task automatic model_edge();
        int op;
        logic [AW-1:0] a;
        logic sel, wr, nd;
        if (!rst_n) begin
            m_base = '0; m_cnt = 0; m_lin = 0; m_act = 0; m_drv = 0;
            m_opq = M_IDLE; m_opq2 = M_IDLE; m_dout = '0; m_raddr = '0;
            return;
        end
        if (sleep) return;
        op = M_IDLE; a = addr;
        sel = !ce0_n && ce1 && !ce2_n;
        wr = !gw_n || !bwe_n;
        if (!ld_n) begin
            if (sel) begin
                op = wr ? M_WR : M_RD;
                m_base = addr; m_cnt = 0; m_lin = seq_lin; m_act = 1;
            end else begin
                op = M_DS; m_act = 0;
            end
        end else if (!adv_n && m_act) begin
            m_cnt = m_cnt + 2'd1;
            a = {m_base[AW-1:2], blo(m_base[1:0], m_cnt, m_lin)};
            op = wr ? M_WR : M_RD;
        end
        nd = m_drv;
        if (m_opq == M_RD) nd = 1;
        else if (m_opq == M_WR) nd = 0;
        else if (m_opq2 == M_DS) nd = 0;
        if (m_opq == M_RD) m_dout = mm[m_raddr];
        m_drv = nd;
        m_opq2 = m_opq;
        m_opq = op;
        if (op == M_RD) m_raddr = a;
        if (op == M_WR) begin
            for (int g = 0; g < NB; g++) begin
                if (!gw_n || !be_n[g]) mm[a][g*8 +: 8] = wdata[g*8 +: 8];
            end
        end
    endtask

    // One clock: model the edge, then compare at the falling edge
    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk({cur_tag, " drive"}, {15'd0, rdata_oe}, {15'd0, m_drv && !oe_n});
        if (m_drv) chk({cur_tag, " data"}, rdata, m_dout);
    endtask

    task automatic quiet();
        ld_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; be_n = '1;
        ce0_n = 0; ce1 = 1; ce2_n = 0;
    endtask

    task automatic idle();
        quiet(); cyc();
    endtask

    task automatic ld_rd(input int a, input logic lin);
        quiet(); ld_n = 0; addr = AW'(a); seq_lin = lin; cyc();
    endtask

    task automatic ld_gw(input int a, input logic [DW-1:0] d);
        quiet(); ld_n = 0; addr = AW'(a); gw_n = 0; bwe_n = 1; be_n = '1; wdata = d; cyc();
    endtask

    task automatic ld_bw(input int a, input logic [DW-1:0] d, input logic [NB-1:0] b);
        quiet(); ld_n = 0; addr = AW'(a); bwe_n = 0; be_n = b; wdata = d; cyc();
    endtask

    task automatic adv_rd();
        quiet(); adv_n = 0; cyc();
    endtask

    task automatic desel();
        quiet(); ld_n = 0; ce1 = 0; cyc();
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mm[i] = '0;
        // R1: reset state
        cur_tag = "R1";
        rst_n = 0;
        cyc(); cyc();
        chk("R1 rdata", rdata, '0);
        chk("R1 oe", {15'd0, rdata_oe}, 16'd0);
        rst_n = 1;
        idle();

        // R5: fill every word with a global write, with be_n all high
        cur_tag = "R5";
        for (int i = 0; i < DEPTH; i++) ld_gw(i, pat(i));
        idle();

        // R2: read at edge k, data after edge k+1
        cur_tag = "R2";
        ld_rd(5, 1);
        idle();
        chk("R2 pipelined", rdata, pat(5));

        // R3: linear burst from low bits 1 -> 1,2,3,0 then wrap to 1
        cur_tag = "R3";
        ld_rd(9, 1);
        adv_rd(); chk("R3 n0", rdata, pat(9));
        adv_rd(); chk("R3 n1", rdata, pat(10));
        adv_rd(); chk("R3 n2", rdata, pat(11));
        adv_rd(); chk("R3 n3", rdata, pat(8));
        idle();   chk("R12 wrap", rdata, pat(9));

        // R4: interleaved burst from low bits 1 -> 1,0,3,2
        cur_tag = "R4";
        ld_rd(13, 0);
        adv_rd(); chk("R4 n0", rdata, pat(13));
        adv_rd(); chk("R4 n1", rdata, pat(12));
        adv_rd(); chk("R4 n2", rdata, pat(15));
        idle();   chk("R4 n3", rdata, pat(14));

        // R13: order changed after load has no effect
        cur_tag = "R13";
        ld_rd(17, 1);
        seq_lin = 0; ld_n = 1; adv_n = 0; cyc(); chk("R13 n0", rdata, pat(17));
        seq_lin = 0; ld_n = 1; adv_n = 0; cyc(); chk("R13 n1", rdata, pat(18));
        idle(); chk("R13 n2", rdata, pat(19));

        // R12: hold cycles do not step the counter
        cur_tag = "R12";
        ld_rd(21, 1);
        idle(); idle();
        adv_rd(); chk("R12 hold", rdata, pat(21));
        idle(); chk("R12 step", rdata, pat(22));

        // R6: byte write lane 1 only (be_n bit1=0), then read-only with both high
        cur_tag = "R6";
        ld_bw(30, 16'hBEEF, 2'b01);
        ld_rd(30, 1);
        idle(); chk("R6 lane1", rdata, {8'hBE, pat(30)[7:0]});
        ld_bw(31, 16'hCAFE, 2'b11);
        ld_rd(31, 1);
        idle(); chk("R6 none", rdata, pat(31));

        // R11: read right after write
        cur_tag = "R11";
        ld_gw(40, 16'h1234);
        ld_rd(40, 1);
        idle(); chk("R11 raw", rdata, 16'h1234);

        // R7: deselected load does not write, advance after it does nothing
        cur_tag = "R7";
        quiet(); ld_n = 0; ce2_n = 1; gw_n = 0; addr = AW'(41); wdata = 16'hDEAD; cyc();
        adv_rd(); adv_rd();
        ld_rd(41, 1); idle(); chk("R7 no write", rdata, pat(41));

        // R8: double-cycle deselect after a read
        cur_tag = "R8";
        ld_rd(42, 1);
        desel();
        chk("R8 on1", {15'd0, rdata_oe}, 16'd1);
        idle();
        chk("R8 on2", {15'd0, rdata_oe}, 16'd1);
        idle();
        chk("R8 off", {15'd0, rdata_oe}, 16'd0);
        // deselect then read keeps driving
        ld_rd(43, 1); desel(); ld_rd(44, 1); idle();
        chk("R8 reread", {15'd0, rdata_oe}, 16'd1);
        // write turns off at next edge
        ld_gw(45, pat(45));
        idle();
        chk("R8 wr off", {15'd0, rdata_oe}, 16'd0);

        // R9: output enable without a clock
        cur_tag = "R9";
        ld_rd(46, 1); idle();
        oe_n = 1; #1;
        chk("R9 off", {15'd0, rdata_oe}, 16'd0);
        oe_n = 0; #1;
        chk("R9 on", {15'd0, rdata_oe}, 16'd1);

        // R10: sleep ignores a write and holds output
        cur_tag = "R10";
        quiet(); sleep = 1; ld_n = 0; gw_n = 0; addr = AW'(46); wdata = 16'h0F0F; cyc();
        chk("R10 hold", rdata, pat(46));
        quiet(); sleep = 1; ld_n = 1; adv_n = 0; cyc();
        sleep = 0;
        ld_rd(46, 1); idle(); chk("R10 array", rdata, pat(46));

        // Random phase
        cur_tag = "R2";
        void'($urandom(32'h1F2E3D4C));
        for (int i = 0; i < 3000; i++) begin
            ld_n    = ($urandom % 3) != 0;
            adv_n   = ($urandom % 2) != 0;
            ce0_n   = ($urandom % 8) == 0;
            ce1     = ($urandom % 8) != 0;
            ce2_n   = ($urandom % 8) == 0;
            gw_n    = ($urandom % 5) != 0;
            bwe_n   = ($urandom % 4) != 0;
            be_n    = NB'($urandom);
            seq_lin = NB'($urandom) != 0;
            oe_n    = ($urandom % 6) == 0;
            sleep   = ($urandom % 20) == 0;
            addr    = AW'($urandom);
            wdata   = DW'($urandom);
            cyc();
        end
        sleep = 0; oe_n = 0;
        idle(); idle(); idle();

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule